// File: doc/BRIEF.md
# Bit-Stream Sine Oscillator

This block produces a sine wave as a single-bit stream. The density of ones in the stream rises and falls sinusoidally, so the stream can drive a two-state power switch directly, with only a little conditioning. No lookup table is used. Two bit-stream integrators form a loop: the first integrator takes the inverted output stream, and the second integrator takes the stream that the first one produces.

Each integrator compares its input bit with a shared zero-reference square wave. The comparison gives a step of +1, -1 or 0, which is added to a saturating accumulator of `ACC_W` bits. A first-order noise-shaping modulator then turns each accumulator back into a bit-stream. A chain of two integrators with the sign reversed once has zero phase margin, so the loop rings at its crossover. That crossover is an angular rate of one radian every N = 2^`ACC_W` bit-rate ticks, which makes one period about 2*pi*N ticks. The period can be changed by changing the tick rate or `ACC_W`.

The bit rate is set by a one-cycle enable `tick_i`. While `init_i` is held, the loop is preset to its starting point. When `init_i` is released, the loop runs freely. Both accumulator values are brought out so that the waveform can be observed directly.

Top module: `bsq_sine_osc`

## Requirements
- R1: While reset or `init_i` is active, integrator A holds +full scale (2^(ACC_W-1)-1, which is 127 for ACC_W=8), integrator B holds 0 and `bit_o` is 0. Ticks are ignored during this time, and the preset applies again whenever `init_i` is raised mid-run.
- R2: In a cycle where `tick_i` is low, neither integrator value changes and `bit_o` does not change.
- R3: On each tick, an integrator moves by at most one count. It moves +1 when its input bit is 1 and the zero reference is 0, and -1 when its input bit is 0 and the reference is 1. The reference is 0 after init and toggles on every tick.
- R4: Both integrators saturate at plus and minus (2^(ACC_W-1)-1) and never wrap. In a free run the waveform reaches at least 110 counts of that 127 limit.
- R5: After release, integrator B follows about 127*sin(k/N) and integrator A follows about 127*cos(k/N), where k counts ticks. B therefore rises first and A falls.
- R6: The fraction of ones in `bit_o` follows integrator B. It is at least 0.8 while B is at or above +96, and at most 0.2 while B is at or below -96.
- R7: The oscillation period, measured between falling sign changes of B, is 2*pi*N ticks within 10%. This holds for the default width and for a width of 6.
- R8: The output toggles more than twice as often per tick while |B| is 16 or less as while |B| is 112 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it applies the preset |
| tick_i | input | 1 | Bit-rate enable: the loop advances one step in each cycle where this is high |
| init_i | input | 1 | 1 = hold the preset, 0 = let the loop run |
| bit_o | output | 1 | Sine-density output bit-stream |
| integ_a_o | output | ACC_W | Integrator A value, two's complement |
| integ_b_o | output | ACC_W | Integrator B value, two's complement |

## Verification
Init and a bit-rate tick can arrive in the same cycle. The bench holds `tick_i` high throughout every init interval, both at start-up and after a short run, and checks that the preset values win on the next sample. Saturation and a unit step also meet at each waveform peak, where the decoded input still asks for growth while the accumulator sits at its limit. The bench judges this case from the recorded extremes and from the largest single-tick move seen on each integrator.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;

   // Decoded quantum of one input bit compared with the zero reference.
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   // A bit that differs from the reference carries one extra quantum.
   function automatic step_e decode_step(input logic bit_i, input logic ref_i);
      if (bit_i && !ref_i)      return STEP_UP;
      else if (!bit_i && ref_i) return STEP_DOWN;
      else                      return STEP_HOLD;
   endfunction

   // Largest magnitude an ACC_W-bit accumulator may hold.
   function automatic int full_scale(input int width);
      return (2 ** (width - 1)) - 1;
   endfunction

endpackage

// File: rtl/bsq_zero_ref.sv
`timescale 1ns/1ps
module bsq_zero_ref (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic init_i,
   output logic ref_o
);

   logic ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ref_q <= 1'b0;
      else if (init_i) ref_q <= 1'b0;
      else if (tick_i) ref_q <= ~ref_q;
   end

   assign ref_o = ref_q;

   // R3: the reference alternates on every running tick
   assert_ref_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !init_i) |=> (ref_q != $past(ref_q)));

   // R2: no tick, no movement
   assert_ref_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !init_i) |=> $stable(ref_q));

endmodule

// File: rtl/bsq_integrator.sv
`timescale 1ns/1ps
module bsq_integrator
   import bsq_pkg::*;
#(
   parameter int ACC_W  = 8,
   parameter int PRESET = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    init_i,
   input  logic                    bit_i,
   input  logic                    ref_i,
   output logic signed [ACC_W-1:0] acc_o
);

   localparam int                    LIMIT   = full_scale(ACC_W);
   localparam logic signed [ACC_W-1:0] LIM_POS = ACC_W'(LIMIT);
   localparam logic signed [ACC_W-1:0] LIM_NEG = ACC_W'(-LIMIT);
   localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1);
   localparam logic signed [ACC_W-1:0] START   = ACC_W'(PRESET);

   if (PRESET > LIMIT || PRESET < -LIMIT) begin : g_bad_preset
      $error("bsq_integrator: PRESET outside the saturating range");
   end

   step_e                    step;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  acc_n;

   always_comb begin
      step  = decode_step(bit_i, ref_i);
      acc_n = acc_q;
      unique case (step)
         STEP_UP:   if (acc_q != LIM_POS) acc_n = acc_q + ONE;
         STEP_DOWN: if (acc_q != LIM_NEG) acc_n = acc_q - ONE;
         default:   acc_n = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= START;
      else if (init_i) acc_q <= START;
      else if (tick_i) acc_q <= acc_n;
   end

   assign acc_o = acc_q;

   // Sign-extended copy for overflow-free differences in the checks.
   logic signed [ACC_W:0] acc_x;
   assign acc_x = {acc_q[ACC_W-1], acc_q};

   // R4: accumulator never leaves the symmetric range
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q <= LIM_POS) && (acc_q >= LIM_NEG));

   // R3: one count per tick at most
   assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !init_i) |=> ((acc_x - $past(acc_x)) <= 1) && (($past(acc_x) - acc_x) <= 1));

   // R2: idle cycles freeze the value
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !init_i) |=> $stable(acc_q));

   // R1: init loads the preset
   assert_preset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (acc_q == START));

endmodule

// File: rtl/bsq_modulator.sv
`timescale 1ns/1ps
module bsq_modulator #(
   parameter int ACC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    init_i,
   input  logic signed [ACC_W-1:0] level_i,
   output logic                    bit_o
);

   // Residue needs two extra bits: |level| + half-scale feedback < 2^(ACC_W+1).
   localparam int                  V_W  = ACC_W + 2;
   localparam logic signed [V_W-1:0] HALF = V_W'(2 ** (ACC_W - 1));

   logic signed [V_W-1:0] resid_q;
   logic signed [V_W-1:0] resid_n;
   logic signed [V_W-1:0] level_x;
   logic                  bit_q;

   assign level_x = {{2{level_i[ACC_W-1]}}, level_i};

   always_comb begin
      if (bit_q) resid_n = resid_q + level_x - HALF;
      else       resid_n = resid_q + level_x + HALF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resid_q <= '0;
         bit_q   <= 1'b0;
      end else if (init_i) begin
         resid_q <= '0;
         bit_q   <= 1'b0;
      end else if (tick_i) begin
         resid_q <= resid_n;
         bit_q   <= ~resid_n[V_W-1];
      end
   end

   assign bit_o = bit_q;

   // R6: a run of ones can only come from a non-negative residue
   assert_residue_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !init_i) |=> (bit_q == (resid_q >= 0)));

   // R2: idle cycles freeze the stream
   assert_mod_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !init_i) |=> ($stable(bit_q) && $stable(resid_q)));

endmodule

// File: rtl/bsq_sine_osc.sv
`timescale 1ns/1ps
module bsq_sine_osc
   import bsq_pkg::*;
#(
   parameter int ACC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    init_i,
   output logic                    bit_o,
   output logic signed [ACC_W-1:0] integ_a_o,
   output logic signed [ACC_W-1:0] integ_b_o
);

   localparam int                    STAGES   = 2;
   localparam int                    FULL_POS = full_scale(ACC_W);
   localparam logic signed [ACC_W-1:0] FULL_V = ACC_W'(FULL_POS);

   if (ACC_W < 3 || ACC_W > 24) begin : g_bad_width
      $error("bsq_sine_osc: ACC_W must lie in 3..24");
   end

   logic                              zref;
   logic [STAGES-1:0]                 stage_in;
   logic [STAGES-1:0]                 stage_bit;
   logic [STAGES-1:0][ACC_W-1:0]      stage_acc;

   bsq_zero_ref u_zref (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .init_i (init_i),
      .ref_o  (zref)
   );

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      // First stage starts at +full scale, later stages at zero.
      localparam int START = (g == 0) ? FULL_POS : 0;

      if (g == 0) begin : g_feedback
         // Inverting every bit swaps +Q and -Q: the loop's single negation.
         assign stage_in[g] = ~stage_bit[STAGES-1];
      end else begin : g_cascade
         assign stage_in[g] = stage_bit[g-1];
      end

      bsq_integrator #(
         .ACC_W  (ACC_W),
         .PRESET (START)
      ) u_integ (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick_i (tick_i),
         .init_i (init_i),
         .bit_i  (stage_in[g]),
         .ref_i  (zref),
         .acc_o  (stage_acc[g])
      );

      bsq_modulator #(
         .ACC_W (ACC_W)
      ) u_mod (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_i  (tick_i),
         .init_i  (init_i),
         .level_i (stage_acc[g]),
         .bit_o   (stage_bit[g])
      );
   end

   assign bit_o     = stage_bit[STAGES-1];
   assign integ_a_o = stage_acc[0];
   assign integ_b_o = stage_acc[STAGES-1];

   // R1: init wins over a simultaneous tick at the block's outputs
   assert_init_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> ((integ_a_o == FULL_V) && (integ_b_o == '0) && !bit_o));

   // R2: the output stream is frozen between ticks
   assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !init_i) |=> $stable(bit_o));

endmodule

// File: tb/bsq_sine_osc_tb.sv
`timescale 1ns/1ps
module bsq_sine_osc_tb;

   localparam int W8 = 8;
   localparam int W6 = 6;

   typedef struct packed {
      int   k;
      logic sel_b;
      int   lo;
      int   hi;
   } vec_t;

   // Quarter-wave checkpoints: B ~ 127 sin(k/256), A ~ 127 cos(k/256)
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{  64, 1'b1,   18,   46},
      '{  64, 1'b0,  105,  127},
      '{ 128, 1'b1,   45,   77},
      '{ 256, 1'b1,   90,  124},
      '{ 256, 1'b0,   50,   88},
      '{ 402, 1'b1,  105,  127},
      '{ 402, 1'b0,  -22,   22},
      '{ 804, 1'b1,  -25,   25},
      '{ 804, 1'b0, -127, -105},
      '{1206, 1'b1, -127, -105}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic init = 1'b1;
   logic bo8, bo6;
   logic signed [W8-1:0] ia8, ib8;
   logic signed [W6-1:0] ia6, ib6;

   always #2.5 clk = ~clk;

   bsq_sine_osc #(.ACC_W(W8)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .init_i(init),
      .bit_o(bo8), .integ_a_o(ia8), .integ_b_o(ib8));

   bsq_sine_osc #(.ACC_W(W6)) u_dut6 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .init_i(init),
      .bit_o(bo6), .integ_a_o(ia6), .integ_b_o(ib6));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int k;
   int pa, pb, pbit, max_step, vmin, vmax;
   bit arm8, arm6;
   int last8, last6, per8, per6, nx8, nx6;
   int hi_t, hi_1, lo_t, lo_1, z_t, z_tog, p_t, p_tog;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input string what,
                            input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   task automatic check_preset(input string what);
      check(int'(ia8) == 127, "R1", {what, " integ A"}, int'(ia8), 127);
      check(int'(ib8) == 0,   "R1", {what, " integ B"}, int'(ib8), 0);
      check(bo8 == 1'b0,      "R1", {what, " bit_o"},   int'(bo8), 0);
   endtask

   // One free-running tick: sample after the edge and accumulate statistics.
   task automatic step_run();
      int a, b, d;
      @(negedge clk);
      k++;
      a = int'(ia8);
      b = int'(ib8);
      d = (a > pa) ? a - pa : pa - a;
      if (d > max_step) max_step = d;
      d = (b > pb) ? b - pb : pb - b;
      if (d > max_step) max_step = d;
      if (a < vmin) vmin = a;
      if (b < vmin) vmin = b;
      if (a > vmax) vmax = a;
      if (b > vmax) vmax = b;
      if (b >= 8) arm8 = 1'b1;
      if (arm8 && b <= -8) begin
         if (last8 > 0) per8 = k - last8;
         last8 = k; nx8++; arm8 = 1'b0;
      end
      if (int'(ib6) >= 4) arm6 = 1'b1;
      if (arm6 && int'(ib6) <= -4) begin
         if (last6 > 0) per6 = k - last6;
         last6 = k; nx6++; arm6 = 1'b0;
      end
      if (b >= 96)  begin hi_t++; hi_1 += int'(bo8); end
      if (b <= -96) begin lo_t++; lo_1 += int'(bo8); end
      if (b >= -16 && b <= 16) begin z_t++; z_tog += int'(bo8 != pbit[0]); end
      if (b >= 112 || b <= -112) begin p_t++; p_tog += int'(bo8 != pbit[0]); end
      pa = a; pb = b; pbit = int'(bo8);
   endtask

   initial begin
      int sa, sb, sbit;
      // Reset state
      repeat (3) @(negedge clk);
      check_preset("reset");
      rst_n = 1'b1;
      // R1: ticks during init are ignored
      tick = 1'b1;
      repeat (10) @(negedge clk);
      check_preset("init with ticks");
      // R2: run a few ticks, then idle
      init = 1'b0;
      repeat (5) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      sa = int'(ia8); sb = int'(ib8); sbit = int'(bo8);
      repeat (10) @(negedge clk);
      check(int'(ia8) == sa,  "R2", "idle integ A", int'(ia8), sa);
      check(int'(ib8) == sb,  "R2", "idle integ B", int'(ib8), sb);
      check(int'(bo8) == sbit, "R2", "idle bit_o",  int'(bo8), sbit);
      // R1: init mid-run with tick high restores the preset
      tick = 1'b1;
      init = 1'b1;
      repeat (3) @(negedge clk);
      check_preset("re-init");
      // Free run from the preset
      k = 0; pa = 127; pb = 0; pbit = 0; max_step = 0; vmin = 0; vmax = 0;
      arm8 = 0; arm6 = 0; last8 = 0; last6 = 0; per8 = 0; per6 = 0; nx8 = 0; nx6 = 0;
      hi_t = 0; hi_1 = 0; lo_t = 0; lo_1 = 0; z_t = 0; z_tog = 0; p_t = 0; p_tog = 0;
      init = 1'b0;
      for (int i = 0; i < NV; i++) begin
         while (k < VECS[i].k) step_run();
         if (VECS[i].sel_b)
            check_rng("R5", $sformatf("integ B at tick %0d", k), int'(ib8), VECS[i].lo, VECS[i].hi);
         else
            check_rng("R5", $sformatf("integ A at tick %0d", k), int'(ia8), VECS[i].lo, VECS[i].hi);
      end
      while (k < 4800) step_run();
      check(max_step <= 1, "R3", "largest step per tick", max_step, 1);
      check(vmin >= -127 && vmax <= 127, "R4", "extremes within +/-127",
            (vmax > -vmin) ? vmax : -vmin, 127);
      check(vmax >= 110 && vmin <= -110, "R4", "amplitude reached",
            (vmax < -vmin) ? vmax : -vmin, 110);
      check(hi_t > 0 && hi_1 * 10 >= hi_t * 8, "R6", "ones per mille near +peak",
            (hi_t > 0) ? hi_1 * 1000 / hi_t : -1, 800);
      check(lo_t > 0 && lo_1 * 10 <= lo_t * 2, "R6", "ones per mille near -peak",
            (lo_t > 0) ? lo_1 * 1000 / lo_t : -1, 200);
      check(nx8 >= 2 && per8 >= 1448 && per8 <= 1769, "R7", "period width 8", per8, 1608);
      check(nx6 >= 2 && per6 >= 362 && per6 <= 442, "R7", "period width 6", per6, 402);
      check(z_t > 0 && p_t > 0 && z_tog * p_t > 2 * p_tog * z_t, "R8",
            "toggles per mille near zero vs peak",
            (z_t > 0) ? z_tog * 1000 / z_t : -1, (p_t > 0) ? 2 * p_tog * 1000 / p_t : -1);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule